// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor that completes one instruction per clock. It runs a small integer subset: add, sub, and, or and slt from the register-to-register group; lw and sw for word memory access; beq and j for control flow.

All state sits inside the block: the program counter, a 64-word instruction store, a 32-entry register file and a 64-word data store. Control comes from the 6-bit opcode alone, with a second small decoder that turns the function field into an ALU operation. In each cycle the core fetches, decodes, executes, accesses memory and writes back. The next PC is chosen from PC+4, the branch target or the jump target.

A host fills both memories through a streaming load port while reset is held. After reset is released, the host watches progress through a combinational register read port. The load port uses a valid/ready handshake. `ld_ready` is high exactly while `rst` is high, so a beat moves only when `ld_valid && ld_ready`. Outside reset every beat is held off indefinitely, and a host that keeps `ld_valid` high just waits for the next reset.

Top module: `sc_cpu`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears all 32 registers. After release the first instruction executed is the one at word 0.
- R2: `ld_ready` equals `rst`. A beat with `ld_valid && ld_ready` writes `ld_data` to word `ld_addr` of instruction memory when `ld_sel`=0, or of data memory when `ld_sel`=1. Beats offered outside reset change neither memory.
- R3: With opcode 0x00, funct 0x20/0x22/0x24/0x25 writes rs+rt, rs-rt, rs&rt and rs|rt respectively to rd (bits 15:11). rs is in bits 25:21 and rt in bits 20:16.
- R4: With opcode 0x00, funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: lw (0x23) and sw (0x2B) use the address rs plus the sign-extended 16-bit offset, and select the memory word with address bits 7:2. lw writes the loaded word to rt. sw stores rt.
- R6: Register 0 always reads as zero. Writes to it are discarded.
- R7: beq (0x04) sets the PC to PC+4+(sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise.
- R8: j (0x02) sets the PC to {PC+4[31:28], instr[25:0], 2'b00}. Instructions it skips have no effect.
- R9: Each instruction retires in exactly one clock. Its register write is visible on the debug port right after the edge that ends its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be taken (high during reset) |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Word index for the load beat |
| ld_data | input | 32 | Word to load |
| dbg_addr | input | 5 | Register number to observe |
| dbg_data | output | 32 | Current content of register `dbg_addr` |

## Verification
Several properties are checked on every cycle: PC alignment, PC+4 sequencing for non-control instructions, taken and untaken branch targets, jump targets, exclusivity of the memory and flow-control signals, a store landing in the addressed word, and register 0 staying zero. Some behaviour only the bench scenarios can show. The arithmetic results, the signed compare, load data reaching rt, and skipped instructions leaving no trace come from a loaded program. A stray load beat during execution is shown to be ignored. A second reset is shown to restart the program from word 0 with cleared registers.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_SLT} aop_e;
  typedef enum logic [1:0] {ACL_ADD, ACL_SUB, ACL_FUNCT} acl_e;

  typedef struct packed {
    logic reg_we;
    logic dst_rd;
    logic src_imm;
    logic mem_rd;
    logic mem_wr;
    logic wb_mem;
    logic is_beq;
    logic is_jmp;
    acl_e acl;
  } ctl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output aop_e       aop
);
  always_comb begin
    ctl = '0;
    ctl.acl = ACL_ADD;
    unique case (opcode)
      OPC_REG:  begin ctl.reg_we = 1'b1; ctl.dst_rd = 1'b1; ctl.acl = ACL_FUNCT; end
      OPC_LOAD: begin ctl.reg_we = 1'b1; ctl.src_imm = 1'b1; ctl.mem_rd = 1'b1; ctl.wb_mem = 1'b1; end
      OPC_STOR: begin ctl.src_imm = 1'b1; ctl.mem_wr = 1'b1; end
      OPC_BEQ:  begin ctl.is_beq = 1'b1; ctl.acl = ACL_SUB; end
      OPC_JMP:  ctl.is_jmp = 1'b1;
      default:  ctl = '0;
    endcase
  end

  always_comb begin
    aop = AOP_ADD;
    unique case (ctl.acl)
      ACL_SUB: aop = AOP_SUB;
      ACL_FUNCT: begin
        unique case (funct)
          FN_SUB:  aop = AOP_SUB;
          FN_AND:  aop = AOP_AND;
          FN_OR:   aop = AOP_OR;
          FN_SLT:  aop = AOP_SLT;
          default: aop = AOP_ADD;
        endcase
      end
      default: aop = AOP_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aop_e         op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      AOP_SUB: y = a - b;
      AOP_AND: y = a & b;
      AOP_OR:  y = a | b;
      AOP_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_d,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_d
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_d = regs[ra_d];

  // R6: the zero register never picks up a value
  p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst) regs[0] == '0);
  // R3: an enabled write to a nonzero register lands there
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW  = $clog2(IMEM_WORDS),
  localparam int DAW  = $clog2(DMEM_WORDS),
  localparam int LAW  = (IAW > DAW) ? IAW : DAW,
  localparam int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_sel,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [RAW-1:0]  dbg_addr,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] pc, pc4, pc_next, br_tgt, j_tgt, seq_or_br;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, mem_q, wb_val;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [RAW-1:0]  wa;
  logic            ld_fire, zero;
  ctl_t            ctl;
  aop_e            aop;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && ld_sel) dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (!rst && ctl.mem_wr) dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign instr = imem[pc[IAW+1:2]];

  sc_decode u_dec (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl), .aop(aop));

  assign wa = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk(clk), .rst(rst), .we(ctl.reg_we && !rst), .wa(wa), .wd(wb_val),
    .ra_a(instr[25:21]), .ra_b(instr[20:16]), .ra_d(dbg_addr),
    .rd_a(rs_val), .rd_b(rt_val), .rd_d(dbg_data)
  );

  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b  = ctl.src_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (.a(rs_val), .b(alu_b), .op(aop), .y(alu_y), .zero(zero));

  assign mem_q  = dmem[alu_y[DAW+1:2]];
  assign wb_val = ctl.wb_mem ? mem_q : alu_y;

  assign pc4       = pc + XLEN'(4);
  assign br_tgt    = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_tgt     = {pc4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign seq_or_br = (ctl.is_beq && zero) ? br_tgt : pc4;
  assign pc_next   = ctl.is_jmp ? j_tgt : seq_or_br;

  // R1: reset forces the PC to word 0
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == '0);
  // R7: the PC stays word aligned
  p_pc_align_r7: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  // R9: non-control instructions advance by one word per clock
  p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.is_beq && !ctl.is_jmp) |=> pc == $past(pc) + XLEN'(4));
  // R7: an untaken branch falls through
  p_beq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_beq && rs_val != rt_val) |=> pc == $past(pc) + XLEN'(4));
  // R7: a taken branch adds the scaled offset to PC+4
  p_beq_take_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_beq && rs_val == rt_val) |=>
      pc == $past(pc) + XLEN'(4) + ($past(imm_sx) << 2));
  // R8: a jump keeps the top nibble and takes the 26-bit field
  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.is_jmp |=> pc[27:0] == {$past(instr[25:0]), 2'b00});
  // R5: memory and flow-control actions are mutually exclusive
  p_ctl_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.mem_rd, ctl.mem_wr, ctl.is_beq, ctl.is_jmp}));
  // R5: a store writes rt into the addressed word
  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |=> dmem[$past(alu_y[DAW+1:2])] == $past(rt_val));
endmodule

// File: tb/test_sc_cpu.sv
module test_sc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sc_cpu i_sc_cpu (.clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // expected register file after the program: {reg, value, requirement}
  localparam logic [40:0] EXPECT [17] = '{
    {5'd1,  32'd5,          4'd5},   // R5 load
    {5'd2,  32'd3,          4'd5},   // R5 load
    {5'd3,  32'hFFFF_FFFF,  4'd5},   // R5 load
    {5'd4,  32'd8,          4'd3},   // R3 add
    {5'd5,  32'd2,          4'd3},   // R3 sub
    {5'd6,  32'd1,          4'd3},   // R3 and
    {5'd7,  32'd7,          4'd3},   // R3 or
    {5'd8,  32'd1,          4'd4},   // R4 3<5
    {5'd9,  32'd0,          4'd4},   // R4 5<3 false
    {5'd10, 32'd1,          4'd4},   // R4 -1<5 signed
    {5'd11, 32'd8,          4'd5},   // R5 store then load
    {5'd0,  32'd0,          4'd6},   // R6 write to r0 dropped
    {5'd12, 32'd5,          4'd7},   // R7 untaken beq falls through
    {5'd13, 32'd0,          4'd7},   // R7 taken beq skips
    {5'd14, 32'd0,          4'd8},   // R8 jump skips
    {5'd15, 32'd6,          4'd8},   // R8 jump target runs
    {5'd16, 32'd3,          4'd5}    // R5 negative offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    dbg_addr = r;
    #1 v = dbg_data;
  endtask

  task automatic beat(input logic sel, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic walk_table(input string pass);
    logic [31:0] v;
    for (int k = 0; k < 17; k++) begin
      peek(EXPECT[k][40:36], v);
      check($sformatf("R%0d %s reg%0d", EXPECT[k][3:0], pass, EXPECT[k][40:36]),
            v, EXPECT[k][35:4]);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] prog [64];
    logic [31:0] v;
    for (int k = 0; k < 64; k++) prog[k] = 32'h0;
    prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h20);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h22);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h24);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'h25);
    prog[7]  = enc_r(5'd2, 5'd1, 5'd8, 6'h2A);
    prog[8]  = enc_r(5'd1, 5'd2, 5'd9, 6'h2A);
    prog[9]  = enc_r(5'd3, 5'd1, 5'd10, 6'h2A);
    prog[10] = enc_i(6'h2B, 5'd0, 5'd4, 16'd16);
    prog[11] = enc_i(6'h23, 5'd0, 5'd11, 16'd16);
    prog[12] = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
    prog[13] = enc_i(6'h04, 5'd1, 5'd2, 16'd1);
    prog[14] = enc_r(5'd1, 5'd0, 5'd12, 6'h20);
    prog[15] = enc_i(6'h04, 5'd4, 5'd11, 16'd1);
    prog[16] = enc_r(5'd1, 5'd1, 5'd13, 6'h20);
    prog[17] = {6'h02, 26'd19};
    prog[18] = enc_r(5'd1, 5'd1, 5'd14, 6'h20);
    prog[19] = enc_r(5'd2, 5'd2, 5'd15, 6'h20);
    prog[20] = enc_i(6'h23, 5'd11, 5'd16, 16'hFFFC);
    prog[21] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

    repeat (2) @(negedge clk);
    check("R2 ready in reset", {31'd0, ld_ready}, 32'd1);
    peek(5'd1, v);
    check("R1 reg cleared in reset", v, 32'd0);

    beat(1'b1, 6'd0, 32'd5);
    beat(1'b1, 6'd1, 32'd3);
    beat(1'b1, 6'd2, 32'hFFFF_FFFF);
    beat(1'b1, 6'd3, 32'd7);
    for (int k = 0; k < 64; k++) beat(1'b0, 6'(k), prog[k]);

    @(negedge clk);
    rst = 1'b0;
    #1 check("R2 ready low out of reset", {31'd0, ld_ready}, 32'd0);
    @(negedge clk);
    peek(5'd1, v);
    check("R9 first load after one clock", v, 32'd5);
    peek(5'd2, v);
    check("R9 second load not yet done", v, 32'd0);
    @(negedge clk);
    peek(5'd2, v);
    check("R9 second load after two clocks", v, 32'd3);

    // R2: a beat offered while running must be refused
    ld_valid = 1'b1; ld_sel = 1'b1; ld_addr = 6'd0; ld_data = 32'd99;
    @(negedge clk);
    ld_valid = 1'b0;

    repeat (40) @(negedge clk);
    walk_table("run1");

    rst = 1'b1;
    @(negedge clk);
    peek(5'd4, v);
    check("R1 regs cleared by second reset", v, 32'd0);
    check("R2 ready back in reset", {31'd0, ld_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    peek(5'd1, v);
    check("R1 restart at word 0, R2 stray beat ignored", v, 32'd5);
    repeat (40) @(negedge clk);
    walk_table("run2");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule